// File: doc/BRIEF.md
# Ternary-Weight Local Accumulator with Zero Skip

This block is the local accumulator for one group of columns in a ternary-weight matrix-vector engine. On each beat it takes one unsigned activation. For every column in its group, it also takes two 2-bit ternary weight codes, which are the two weights held by one storage cell. A direction bit picks which of the two codes is used. Each selected code places its column in one of three modes: skip, add or subtract. The signed terms from all columns are summed and folded into one shared accumulator. The block has no multiplier.

A last-beat strobe marks the end of an input slice. On that beat the block moves the running sum plus the current beat's terms into an output register, raises a one-cycle valid flag for the downstream adder tree, and clears the accumulator. The next slice therefore starts from zero with no idle cycle between slices. When every column of a beat is in skip mode, the accumulator register is not clock-enabled.

Top module: `tacc_local_unit`

## Requirements
- R1: After reset is released, `psum_o` is 0 and `psum_valid_o` is 0. The accumulator starts at 0.
- R2: Weight code 2'b01 adds the activation and 2'b11 subtracts it. Code 2'b00 contributes nothing, and the illegal code 2'b10 behaves exactly like 2'b00.
- R3: Column c uses bits [2c+1:2c] of `wgt_fwd_i` when `dir_i` is 0 and of `wgt_rev_i` when `dir_i` is 1. The unselected code has no effect.
- R4: On a beat with `beat_i` high, the terms of all columns of the group are added into the single accumulator.
- R5: While `beat_i` is low, the accumulator does not change, `last_i` is ignored and `psum_valid_o` stays 0.
- R6: On a beat with `beat_i` and `last_i` both high, `psum_o` takes the accumulated sum including that beat's terms. `psum_valid_o` is high in the next cycle only, and the following slice starts from zero.
- R7: `psum_o` holds its value in every cycle where `psum_valid_o` is low.
- R8: A slice of up to MAX_SLICE beats with every term at the largest activation magnitude, all added or all subtracted, produces the exact signed sum without overflow.
- R9: A beat whose selected weights are all zero (skip mode in every column) leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| beat_i | input | 1 | Activation and weights are valid this cycle |
| act_i | input | ACT_W | Unsigned activation |
| wgt_fwd_i | input | 2*NUM_COLS | Weight codes read in the forward direction, 2 bits per column |
| wgt_rev_i | input | 2*NUM_COLS | Weight codes read in the reverse direction, 2 bits per column |
| dir_i | input | 1 | Read direction: 0 forward, 1 reverse |
| last_i | input | 1 | Final beat of the current slice |
| psum_o | output | ACC_W | Signed partial sum of the finished slice |
| psum_valid_o | output | 1 | One-cycle pulse when `psum_o` is updated |

## Verification
The overflow check assumes the input side never feeds a slice longer than MAX_SLICE beats. The checker counts beats in each slice, and the bound on the accumulator applies only while that count is within the limit. The bench keeps its random slices to eight beats or fewer and runs the full-length extreme slices exactly at MAX_SLICE. The other properties assume only that `last_i` is read together with `beat_i`. The bench drives `last_i` high on idle cycles on purpose, to show that the block ignores it.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  typedef enum logic [1:0] {
    MODE_SKIP = 2'd0,
    MODE_ADD  = 2'd1,
    MODE_SUB  = 2'd2
  } tacc_mode_e;

  // 00 zero, 01 plus one, 11 minus one, 10 illegal -> zero
  function automatic tacc_mode_e decode_code(input logic [1:0] code);
    unique case (code)
      2'b01:   decode_code = MODE_ADD;
      2'b11:   decode_code = MODE_SUB;
      default: decode_code = MODE_SKIP;
    endcase
  endfunction
endpackage

// File: rtl/tacc_wdecode.sv
module tacc_wdecode #(
  parameter int NUM_COLS = 4
) (
  input  logic [2*NUM_COLS-1:0] wgt_fwd_i,
  input  logic [2*NUM_COLS-1:0] wgt_rev_i,
  input  logic                  dir_i,
  output logic [NUM_COLS-1:0]   add_o,
  output logic [NUM_COLS-1:0]   sub_o,
  output logic                  active_o
);
  import tacc_pkg::*;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [1:0] code;
    tacc_mode_e mode;
    assign code     = dir_i ? wgt_rev_i[2*c +: 2] : wgt_fwd_i[2*c +: 2];
    assign mode     = decode_code(code);
    assign add_o[c] = (mode == MODE_ADD);
    assign sub_o[c] = (mode == MODE_SUB);
  end

  assign active_o = |(add_o | sub_o);
endmodule

// File: rtl/tacc_term.sv
module tacc_term #(
  parameter int NUM_COLS = 4,
  parameter int ACT_W    = 4,
  localparam int TERM_W  = ACT_W + 1
) (
  input  logic [ACT_W-1:0]           act_i,
  input  logic [NUM_COLS-1:0]        add_i,
  input  logic [NUM_COLS-1:0]        sub_i,
  output logic [NUM_COLS*TERM_W-1:0] terms_o
);
  logic [TERM_W-1:0] act_pos;
  logic [TERM_W-1:0] act_neg;

  assign act_pos = {1'b0, act_i};
  assign act_neg = ~act_pos + TERM_W'(1);  // two's complement, no subtractor

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_comb begin
      terms_o[c*TERM_W +: TERM_W] = '0;
      if (add_i[c])      terms_o[c*TERM_W +: TERM_W] = act_pos;
      else if (sub_i[c]) terms_o[c*TERM_W +: TERM_W] = act_neg;
    end
  end
endmodule

// File: rtl/tacc_group_sum.sv
module tacc_group_sum #(
  parameter int NUM_COLS = 4,
  parameter int TERM_W   = 5,
  localparam int GSUM_W  = TERM_W + $clog2(NUM_COLS)
) (
  input  logic [NUM_COLS*TERM_W-1:0] terms_i,
  output logic signed [GSUM_W-1:0]   gsum_o
);
  always_comb begin
    logic signed [TERM_W-1:0] t;
    gsum_o = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      t      = terms_i[c*TERM_W +: TERM_W];
      gsum_o = gsum_o + GSUM_W'(t);
    end
  end
endmodule

// File: rtl/tacc_acc_reg.sv
module tacc_acc_reg #(
  parameter int GSUM_W = 7,
  parameter int ACC_W  = 13
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     beat_i,
  input  logic                     last_i,
  input  logic                     active_i,
  input  logic signed [GSUM_W-1:0] gsum_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic signed [ACC_W-1:0]  psum_o,
  output logic                     psum_valid_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_sum;
  logic                    close_slice;
  logic                    acc_en;

  assign acc_sum     = acc_q + ACC_W'(gsum_i);
  assign close_slice = beat_i && last_i;
  // skip beats leave the register gated off
  assign acc_en      = close_slice || (beat_i && active_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         acc_q <= '0;
    else if (acc_en)     acc_q <= close_slice ? '0 : acc_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_o       <= '0;
      psum_valid_o <= 1'b0;
    end else begin
      psum_valid_o <= close_slice;
      if (close_slice) psum_o <= acc_sum;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tacc_local_unit.sv
module tacc_local_unit #(
  parameter int NUM_COLS  = 4,
  parameter int ACT_W     = 4,
  parameter int MAX_SLICE = 64,
  localparam int TERM_W   = ACT_W + 1,
  localparam int GSUM_W   = TERM_W + $clog2(NUM_COLS),
  localparam int ACC_W    = $clog2(MAX_SLICE * NUM_COLS * (2**ACT_W - 1) + 1) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    beat_i,
  input  logic [ACT_W-1:0]        act_i,
  input  logic [2*NUM_COLS-1:0]   wgt_fwd_i,
  input  logic [2*NUM_COLS-1:0]   wgt_rev_i,
  input  logic                    dir_i,
  input  logic                    last_i,
  output logic signed [ACC_W-1:0] psum_o,
  output logic                    psum_valid_o
);
  logic [NUM_COLS-1:0]        add_sel;
  logic [NUM_COLS-1:0]        sub_sel;
  logic                       any_active;
  logic [NUM_COLS*TERM_W-1:0] terms;
  logic signed [GSUM_W-1:0]   gsum;
  logic signed [ACC_W-1:0]    acc_q;

  tacc_wdecode #(.NUM_COLS(NUM_COLS)) u_dec (
    .wgt_fwd_i (wgt_fwd_i),
    .wgt_rev_i (wgt_rev_i),
    .dir_i     (dir_i),
    .add_o     (add_sel),
    .sub_o     (sub_sel),
    .active_o  (any_active)
  );

  tacc_term #(.NUM_COLS(NUM_COLS), .ACT_W(ACT_W)) u_term (
    .act_i   (act_i),
    .add_i   (add_sel),
    .sub_i   (sub_sel),
    .terms_o (terms)
  );

  tacc_group_sum #(.NUM_COLS(NUM_COLS), .TERM_W(TERM_W)) u_sum (
    .terms_i (terms),
    .gsum_o  (gsum)
  );

  tacc_acc_reg #(.GSUM_W(GSUM_W), .ACC_W(ACC_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_i       (beat_i),
    .last_i       (last_i),
    .active_i     (any_active),
    .gsum_i       (gsum),
    .acc_o        (acc_q),
    .psum_o       (psum_o),
    .psum_valid_o (psum_valid_o)
  );
endmodule

// File: rtl/tacc_local_unit_chk.sv
module tacc_local_unit_chk #(
  parameter int NUM_COLS  = 4,
  parameter int ACT_W     = 4,
  parameter int MAX_SLICE = 64,
  parameter int ACC_W     = 13
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    beat_i,
  input logic                    last_i,
  input logic                    any_active,
  input logic signed [ACC_W-1:0] acc_q,
  input logic signed [ACC_W-1:0] psum_o,
  input logic                    psum_valid_o
);
  localparam int BOUND = MAX_SLICE * NUM_COLS * (2**ACT_W - 1);
  localparam int CNT_W = $clog2(MAX_SLICE + 2);

  logic             past_ok;
  logic [CNT_W-1:0] slice_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      slice_cnt <= '0;
    else if (beat_i && last_i)        slice_cnt <= '0;
    else if (beat_i && slice_cnt <= CNT_W'(MAX_SLICE)) slice_cnt <= slice_cnt + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> (acc_q == 0 && psum_o == 0 && !psum_valid_o));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    !beat_i |=> ($stable(acc_q) && !psum_valid_o));

  // R6
  close_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (beat_i && last_i) |=> (psum_valid_o && acc_q == 0));

  // R6
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    psum_valid_o |-> $past(beat_i && last_i));

  // R7
  psum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    !psum_valid_o |-> $stable(psum_o));

  // R9
  skip_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (beat_i && !last_i && !any_active) |=> $stable(acc_q));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slice_cnt <= CNT_W'(MAX_SLICE)) |-> (int'(acc_q) <= BOUND && int'(acc_q) >= -BOUND));
endmodule

bind tacc_local_unit tacc_local_unit_chk #(
  .NUM_COLS (NUM_COLS),
  .ACT_W    (ACT_W),
  .MAX_SLICE(MAX_SLICE),
  .ACC_W    (ACC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_i       (beat_i),
  .last_i       (last_i),
  .any_active   (any_active),
  .acc_q        (acc_q),
  .psum_o       (psum_o),
  .psum_valid_o (psum_valid_o)
);

// File: tb/sim_tacc_local_unit.sv
`timescale 1ns/1ps
module sim_tacc_local_unit;
  localparam int NUM_COLS  = 4;
  localparam int ACT_W     = 4;
  localparam int MAX_SLICE = 64;
  localparam int AMAX      = 2**ACT_W - 1;
  localparam int ACC_W     = $clog2(MAX_SLICE * NUM_COLS * AMAX + 1) + 1;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    beat_i = 1'b0;
  logic [ACT_W-1:0]        act_i = '0;
  logic [2*NUM_COLS-1:0]   wgt_fwd_i = '0;
  logic [2*NUM_COLS-1:0]   wgt_rev_i = '0;
  logic                    dir_i = 1'b0;
  logic                    last_i = 1'b0;
  logic signed [ACC_W-1:0] psum_o;
  logic                    psum_valid_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    ref_acc = 0;
  int    ref_psum = 0;
  bit    ref_valid = 0;
  string tag = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  tacc_local_unit #(.NUM_COLS(NUM_COLS), .ACT_W(ACT_W), .MAX_SLICE(MAX_SLICE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .beat_i(beat_i), .act_i(act_i),
    .wgt_fwd_i(wgt_fwd_i), .wgt_rev_i(wgt_rev_i), .dir_i(dir_i),
    .last_i(last_i), .psum_o(psum_o), .psum_valid_o(psum_valid_o)
  );

  function automatic int code_val(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  task automatic check(input string t, input int act_v, input int exp_v);
    n_tests++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act_v, exp_v);
    end
  endtask

  task automatic beat(input bit v, input int a, input logic [2*NUM_COLS-1:0] wf,
                      input logic [2*NUM_COLS-1:0] wr, input bit d, input bit l);
    int contrib;
    @(negedge clk);
    beat_i = v; act_i = ACT_W'(a); wgt_fwd_i = wf; wgt_rev_i = wr;
    dir_i = d; last_i = l;
    contrib = 0;
    for (int c = 0; c < NUM_COLS; c++)
      contrib += a * code_val(d ? wr[2*c +: 2] : wf[2*c +: 2]);
    if (v && l) begin
      ref_psum = ref_acc + contrib; ref_valid = 1; ref_acc = 0;
    end else begin
      ref_valid = 0;
      if (v) ref_acc += contrib;
    end
    @(posedge clk); #1;
    check({tag, " valid"}, int'(psum_valid_o), int'(ref_valid));
    check({tag, " psum"}, int'(psum_o), ref_psum);
  endtask

  // close a slice with an all-zero beat to expose the running sum
  task automatic flush();
    beat(1, 0, '0, '0, 0, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(psum_valid_o), 0);
    check("R1 reset psum", int'(psum_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", int'(psum_o), 0);
    tag = "R1"; flush();

    // R2: single column codes, others zero
    tag = "R2 add";     beat(1, 9, 8'b0000_0001, '0, 0, 1);
    tag = "R2 sub";     beat(1, 9, 8'b0000_0011, '0, 0, 1);
    tag = "R2 zero";    beat(1, 9, 8'b0000_0000, '0, 0, 1);
    tag = "R2 illegal"; beat(1, 9, 8'b1010_1010, '0, 0, 1);
    tag = "R2 mixed";   beat(1, 7, 8'b1011_0111, '0, 0, 1);

    // R3: direction chooses the code set
    tag = "R3 fwd"; beat(1, 5, 8'b0101_0101, 8'b1111_1111, 0, 1);
    tag = "R3 rev"; beat(1, 5, 8'b0101_0101, 8'b1111_1111, 1, 1);
    tag = "R3 rev only"; beat(1, 3, 8'b1111_1111, 8'b0000_0001, 1, 1);

    // R4: multi-beat slice, all columns summed
    tag = "R4";
    beat(1, 15, 8'b0101_0101, '0, 0, 0);
    beat(1, 2,  8'b1101_0111, '0, 0, 0);
    beat(1, 6,  '0, 8'b0111_0101, 1, 0);
    beat(1, 1,  8'b0101_0001, '0, 0, 1);

    // R5: idle cycles with last_i high are ignored
    tag = "R5";
    beat(1, 4, 8'b0101_0101, '0, 0, 0);
    beat(0, 15, 8'b0101_0101, '0, 0, 1);
    beat(0, 15, 8'b1111_1111, '0, 0, 1);
    beat(1, 1, 8'b0000_0001, '0, 0, 1);

    // R9: skip beats mid-slice leave the sum alone
    tag = "R9";
    beat(1, 3, 8'b0000_0101, '0, 0, 0);
    beat(1, 15, 8'b1010_0000, 8'b0101_0101, 0, 0);
    beat(1, 15, '0, '0, 1, 0);
    flush();

    // R6: back-to-back slices, each starts from zero
    tag = "R6";
    beat(1, 10, 8'b0101_0101, '0, 0, 1);
    beat(1, 10, 8'b0000_0001, '0, 0, 1);
    beat(1, 2,  8'b0000_0011, '0, 0, 0);
    beat(1, 2,  8'b0000_0011, '0, 0, 1);

    // R7: output holds over idle and accumulating beats
    tag = "R7";
    for (int i = 0; i < 5; i++) beat(i % 2, 8, 8'b0101_0101, '0, 0, 0);
    flush();

    // R8: full-length extreme slices
    tag = "R8 pos";
    for (int i = 0; i < MAX_SLICE; i++) beat(1, AMAX, 8'b0101_0101, '0, 0, i == MAX_SLICE-1);
    check("R8 pos total", int'(psum_o), MAX_SLICE * NUM_COLS * AMAX);
    tag = "R8 neg";
    for (int i = 0; i < MAX_SLICE; i++) beat(1, AMAX, '0, 8'b1111_1111, 1, i == MAX_SLICE-1);
    check("R8 neg total", int'(psum_o), -MAX_SLICE * NUM_COLS * AMAX);

    // R4 random slices, up to eight beats each
    tag = "R4 random";
    for (int s = 0; s < 60; s++) begin
      int len;
      len = 1 + ($urandom % 8);
      for (int k = 0; k < len; k++) begin
        bit v;
        v = ($urandom % 4) != 0;
        beat(v, $urandom % 16, 8'($urandom), 8'($urandom), 1'($urandom),
             (k == len-1) ? 1'b1 : 1'($urandom % 8 == 0));
      end
      flush();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule